// File: doc/BRIEF.md
# Counterflow Convolution Array with Resident Accumulators

This block computes a one-dimensional convolution on a linear chain of multiply-accumulate cells. Each cell keeps one running sum. Samples enter at the left end and move one cell to the right per cycle. Weights enter at the right end and move one cell to the left per cycle. Each stream fills every second slot, so every sample meets every weight. When a valid sample and a valid weight are in the same cell in the same cycle, the cell adds their product to its sum.

The host repeats the weight sequence w1..wK without end and marks w1 with a "first" flag. When the flagged weight reaches a cell, the cell does two things. It pushes its finished sum onto a neighbour-to-neighbour drain chain that runs toward the right end. It then starts a new sum with the product of that cycle. Results leave the right end in increasing index order, one every second cycle, with no shared bus.

Top module: `sa_conv_top`

## Requirements
- R1: Samples x0, x1, … are driven on input cycles t = 2n, and weight slot s is driven on cycle 2s + ((K−1) mod 2). The weight slots cycle through w1..wK, with the first flag set on w1 only. Under this timing the result stream equals y_j = Σ_{m=1..K} w_m·x_{j+m−1}, starting at j0 = ⌈(K−1)/2⌉ − K + 1, which is −1 for K = 4. Samples outside the driven stream count as zero.
- R2: A sample slot with its valid bit low contributes zero to every sum, whatever its data.
- R3: A weight slot with its valid bit low has no effect, even when its first flag and data are set.
- R4: Results appear in strictly increasing j and never on two consecutive cycles. Within one continuous run, successive results are exactly two cycles apart.
- R5: After reset, the first flagged weight to reach a cell produces no result. The first value out is y_j0.
- R6: No result is lost on the drain chain. B complete weight passes yield exactly K·(B−1) results.
- R7: During reset, and on the first cycle after it, the result valid output is low and the result data is zero. A stream started after a reset that came in mid-run gives exact results.
- R8: Arithmetic is exact and signed for 8-bit operands at their most negative value. The accumulator is 8+8+4 bits wide.
- R9: A flagged weight starts a fresh sum, so each result holds only the terms from its own weight pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample slot carries data |
| smp_dat | input | 8 | Signed sample value |
| wgt_vld | input | 1 | Weight slot carries data |
| wgt_first | input | 1 | Marks w1 of a weight pass |
| wgt_dat | input | 8 | Signed weight value |
| res_vld | output | 1 | Result slot leaving the drain chain is valid |
| res_dat | output | 20 | Signed finished convolution sum |

## Verification
The hardest case to reach from the ports is a result being pushed into a drain latch in the same cycle that a result from further left is passing through it. The other is a cell whose first flag arrives before it has a real sum. The stimulus drives several back-to-back weight passes so that every cell drains while other results flow past it. It fills idle weight slots with a set first flag and nonzero data. It also resets the array part-way through a stream, then checks that the restarted run is exact from its first value.

// File: rtl/sa_conv_pkg.sv
package sa_conv_pkg;

    localparam int SAMP_W    = 8;
    localparam int WGT_W     = 8;
    localparam int ACC_GUARD = 4;
    localparam int ACC_W     = SAMP_W + WGT_W + ACC_GUARD;

    typedef logic signed [SAMP_W-1:0] samp_d_t;
    typedef logic signed [WGT_W-1:0]  wgt_d_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef struct packed {
        logic    vld;
        samp_d_t val;
    } samp_slot_t;

    typedef struct packed {
        logic   vld;
        logic   first;
        wgt_d_t val;
    } wgt_slot_t;

    typedef struct packed {
        logic vld;
        acc_t sum;
    } res_slot_t;

    // Product of a meeting; zero unless both operands are present.
    function automatic acc_t meet_term(samp_slot_t s, wgt_slot_t w);
        acc_t p;
        if (s.vld && w.vld)
            p = acc_t'(s.val) * acc_t'(w.val);
        else
            p = '0;
        return p;
    endfunction

    function automatic logic pass_start(wgt_slot_t w);
        return w.vld & w.first;
    endfunction

endpackage

// File: rtl/sa_conv_drain.sv
module sa_conv_drain
    import sa_conv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  acc_t      sum_i,
    input  res_slot_t path_i,
    output res_slot_t path_o
);

    res_slot_t path_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            path_q <= '0;
        end else if (load) begin
            path_q.vld <= 1'b1;
            path_q.sum <= sum_i;
        end else begin
            path_q <= path_i;
        end
    end

    assign path_o = path_q;

endmodule

// File: rtl/sa_conv_cell.sv
module sa_conv_cell
    import sa_conv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  samp_slot_t smp_i,
    input  wgt_slot_t  wgt_i,
    input  res_slot_t  path_i,
    output samp_slot_t smp_o,
    output wgt_slot_t  wgt_o,
    output res_slot_t  path_o,
    output logic       drain_o
);

    samp_slot_t smp_q;
    wgt_slot_t  wgt_q;
    acc_t       acc_q;
    logic       armed_q;
    acc_t       term;
    logic       tag_hit;

    always_comb begin
        term    = meet_term(smp_q, wgt_q);
        tag_hit = pass_start(wgt_q);
    end

    assign drain_o = tag_hit & armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q   <= '0;
            wgt_q   <= '0;
            acc_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            smp_q <= smp_i;
            wgt_q <= wgt_i;
            if (tag_hit) begin
                acc_q   <= term;
                armed_q <= 1'b1;
            end else begin
                acc_q <= acc_q + term;
            end
        end
    end

    sa_conv_drain u_drain (
        .clk    (clk),
        .rst    (rst),
        .load   (drain_o),
        .sum_i  (acc_q),
        .path_i (path_i),
        .path_o (path_o)
    );

    assign smp_o = smp_q;
    assign wgt_o = wgt_q;

endmodule

// File: rtl/sa_conv_top.sv
module sa_conv_top
    import sa_conv_pkg::*;
#(
    parameter int CELLS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_vld,
    input  logic [SAMP_W-1:0] smp_dat,
    input  logic              wgt_vld,
    input  logic              wgt_first,
    input  logic [WGT_W-1:0]  wgt_dat,
    output logic              res_vld,
    output logic [ACC_W-1:0]  res_dat
);

    localparam int LAST = CELLS - 1;

    samp_slot_t head;
    wgt_slot_t  tail;
    samp_slot_t smp_q  [CELLS];
    wgt_slot_t  wgt_q  [CELLS];
    res_slot_t  path_q [CELLS];
    logic [CELLS-1:0] drain_vec;
    logic [CELLS-1:0] pass_vec;

    always_comb begin
        head.vld   = smp_vld;
        head.val   = samp_d_t'(smp_dat);
        tail.vld   = wgt_vld;
        tail.first = wgt_first;
        tail.val   = wgt_d_t'(wgt_dat);
    end

    for (genvar g = 0; g < CELLS; g++) begin : g_cell
        samp_slot_t s_in;
        wgt_slot_t  w_in;
        res_slot_t  r_in;

        if (g == 0) begin : g_left
            assign s_in = head;
            assign r_in = '0;
        end else begin : g_inner_l
            assign s_in = smp_q[g-1];
            assign r_in = path_q[g-1];
        end

        if (g == LAST) begin : g_right
            assign w_in = tail;
        end else begin : g_inner_r
            assign w_in = wgt_q[g+1];
        end

        assign pass_vec[g] = r_in.vld;

        sa_conv_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .smp_i   (s_in),
            .wgt_i   (w_in),
            .path_i  (r_in),
            .smp_o   (smp_q[g]),
            .wgt_o   (wgt_q[g]),
            .path_o  (path_q[g]),
            .drain_o (drain_vec[g])
        );
    end

    assign res_vld = path_q[LAST].vld;
    assign res_dat = path_q[LAST].sum;

endmodule

// File: rtl/sa_conv_chk.sv
module sa_conv_chk
    import sa_conv_pkg::*;
#(
    parameter int CELLS = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_vld,
    input logic             wgt_vld,
    input logic             res_vld,
    input logic [ACC_W-1:0] res_dat,
    input logic [CELLS-1:0] drain_vec,
    input logic [CELLS-1:0] pass_vec
);

    AST_DRAIN_NO_COLLIDE: assert property (@(posedge clk) disable iff (rst)
        (drain_vec & pass_vec) == '0); // R6

    AST_RES_SPACED: assert property (@(posedge clk) disable iff (rst)
        res_vld |=> !res_vld); // R4

    AST_RES_KNOWN: assert property (@(posedge clk) disable iff (rst)
        res_vld |-> !$isunknown(res_dat)); // R1

    AST_QUIET_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !res_vld); // R7

    AST_SMP_SPARSE: assert property (@(posedge clk) disable iff (rst)
        smp_vld |=> !smp_vld); // R1

    AST_WGT_SPARSE: assert property (@(posedge clk) disable iff (rst)
        wgt_vld |=> !wgt_vld); // R1

endmodule

bind sa_conv_top sa_conv_chk #(.CELLS(CELLS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_vld   (smp_vld),
    .wgt_vld   (wgt_vld),
    .res_vld   (res_vld),
    .res_dat   (res_dat),
    .drain_vec (drain_vec),
    .pass_vec  (pass_vec)
);

// File: tb/sa_conv_top_tb.sv
`timescale 1ns/1ps
module sa_conv_top_tb;
    import sa_conv_pkg::*;

    localparam int K     = 4;
    localparam int PAR   = (K - 1) % 2;
    localparam int J0    = (K - 1 + PAR) / 2 - K + 1;
    localparam int NCASE = 5;
    localparam int MAXR  = 128;

    // Stimulus table: weights w1..w4, sample base, step, length, hole index.
    localparam int CW    [NCASE][K] = '{'{1, 2, 3, 4}, '{1, 1, 1, 1},
                                        '{-3, 5, -7, 2}, '{-128, -128, -128, -128},
                                        '{2, -1, 4, 3}};
    localparam int CBASE [NCASE] = '{1, 1, -20, -128, 5};
    localparam int CSTEP [NCASE] = '{0, 1, 7, 0, -3};
    localparam int CLEN  [NCASE] = '{1, 10, 12, 8, 10};
    localparam int CHOLE [NCASE] = '{-1, -1, -1, -1, 4};

    logic             clk = 1'b0;
    logic             rst;
    logic             smp_vld;
    logic [SAMP_W-1:0] smp_dat;
    logic             wgt_vld;
    logic             wgt_first;
    logic [WGT_W-1:0]  wgt_dat;
    logic             res_vld;
    logic [ACC_W-1:0]  res_dat;

    always #2 clk = ~clk;

    sa_conv_top #(.CELLS(K)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .smp_vld   (smp_vld),
        .smp_dat   (smp_dat),
        .wgt_vld   (wgt_vld),
        .wgt_first (wgt_first),
        .wgt_dat   (wgt_dat),
        .res_vld   (res_vld),
        .res_dat   (res_dat)
    );

    int n_chk = 0;
    int n_err = 0;
    int got   [MAXR];
    int got_t [MAXR];
    int n_got;
    int last_nb;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    function automatic string req_of(input int ci);
        case (ci)
            0: return "R3";
            1: return "R9";
            2: return "R1";
            3: return "R8";
            default: return "R2";
        endcase
    endfunction

    function automatic int xval(input int ci, input int n);
        logic signed [7:0] b;
        if (n < 0 || n >= CLEN[ci] || n == CHOLE[ci]) return 0;
        b = 8'(CBASE[ci] + CSTEP[ci] * n);
        return int'(b);
    endfunction

    function automatic int exp_y(input int ci, input int j);
        int acc = 0;
        for (int m = 0; m < K; m++) acc += CW[ci][m] * xval(ci, j + m);
        return acc;
    endfunction

    task automatic idle_inputs(input int t);
        smp_vld   = 1'b0;
        smp_dat   = 8'(t * 37 + 11);
        wgt_vld   = 1'b0;
        wgt_first = 1'b1;
        wgt_dat   = 8'(t * 13 + 5);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        idle_inputs(0);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check(res_vld == 1'b0, "R7", int'(res_vld), 0);
            check(res_dat == '0, "R7", int'(res_dat), 0);
        end
        rst = 1'b0;
    endtask

    task automatic run_case(input int ci, input int stop_at);
        int nb;
        int t_end;
        nb      = CLEN[ci] / K + 3;
        last_nb = nb;
        t_end   = 2 * K * nb + 3 * K + 12;
        n_got   = 0;
        for (int t = 0; t < t_end; t++) begin
            @(negedge clk);
            if (res_vld && n_got < MAXR) begin
                got[n_got]   = int'($signed(res_dat));
                got_t[n_got] = t;
                n_got++;
            end
            if (t == stop_at) return;
            idle_inputs(t);
            if (t % 2 == 0 && t / 2 < CLEN[ci] && t / 2 != CHOLE[ci]) begin
                smp_vld = 1'b1;
                smp_dat = 8'(CBASE[ci] + CSTEP[ci] * (t / 2));
            end
            if (t >= PAR && t % 2 == PAR && (t - PAR) / 2 < K * nb) begin
                wgt_vld   = 1'b1;
                wgt_first = (((t - PAR) / 2) % K) == 0;
                wgt_dat   = 8'(CW[ci][((t - PAR) / 2) % K]);
            end
        end
    endtask

    task automatic verify_case(input int ci);
        int want;
        want = K * (last_nb - 1);
        check(n_got == want, "R6", n_got, want);
        for (int k = 0; k < n_got && k < want; k++)
            check(got[k] == exp_y(ci, J0 + k), req_of(ci), got[k], exp_y(ci, J0 + k));
        for (int k = 1; k < n_got; k++)
            check(got_t[k] - got_t[k-1] == 2, "R4", got_t[k] - got_t[k-1], 2);
    endtask

    initial begin
        #400000;
        n_err++;
        $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        rst = 1'b1;
        idle_inputs(0);
        repeat (3) @(negedge clk);
        check(res_vld == 1'b0, "R7", int'(res_vld), 0);
        check(res_dat == '0, "R7", int'(res_dat), 0);
        rst = 1'b0;

        // Table walk: R1, R2 (hole), R3 (flagged idle slots), R8, R9.
        for (int ci = 0; ci < NCASE; ci++) begin
            apply_reset();
            run_case(ci, -1);
            verify_case(ci);
            if (ci == 0)
                check(n_got > 0 && got[0] == CW[0][1], "R5",
                      n_got > 0 ? got[0] : -999, CW[0][1]);
        end

        // Reset in the middle of a stream, then rerun: R7.
        apply_reset();
        run_case(2, 25);
        apply_reset();
        @(negedge clk);
        check(res_vld == 1'b0, "R7", int'(res_vld), 0);
        run_case(2, -1);
        verify_case(2);
        check(n_got > 0 && got[0] == exp_y(2, J0), "R7",
              n_got > 0 ? got[0] : -999, exp_y(2, J0));

        summary();
    end

endmodule